// File: doc/BRIEF.md
# Multichannel Limit Alert Monitor

This block watches a stream of 12-bit conversion results. Each result carries a channel tag. Tags 0 to 7 are voltage channels, tag 8 is the instantaneous temperature result and tag 9 is the averaged temperature result. Each accepted result is compared with that channel's upper and lower limits. A violation raises the `alert` output and sets a sticky status bit for that channel and direction. A raised alert side drops again only after the result has moved back past its limit by the channel's hysteresis value N.

A small register port gives software access to the limits, the hysteresis values and the two status words, and it carries a command that clears all status bits. Reads are combinational from `reg_addr`. Writes take effect at the clock edge while `reg_wr` is high.

The address map has four banks, selected by address bits 5:4. In each of the first three banks, bits 3:0 give the channel:
- 0x00+k is the upper limit of channel k.
- 0x10+k is the lower limit of channel k.
- 0x20+k is the hysteresis value of channel k.
- 0x30 is status word A and 0x31 is status word B.
- 0x3F is the command register.

Top module: `limit_alert_mon`

## Requirements
- R1: Each of the ten hysteresis registers (0x20..0x29) holds 12 bits. Bits 15:12 always read as zero, and every hysteresis register reads 0x0000 after reset.
- R2: After reset, every upper limit reads 0x0FFF, every lower limit reads 0x0000 and `alert` is low, so no result can raise an alert until the limits are changed.
- R3: A result strictly above its channel's upper limit makes `alert` high in the cycle after the result is accepted, and sets that channel's high status bit.
- R4: A raised high side stays raised until a result arrives that is strictly below (upper − N). That threshold saturates at 0, so with N > upper the side never releases.
- R5: A result strictly below the lower limit raises the low side and sets the low status bit. The low side releases only on a result strictly above (lower + N), with that threshold saturated at 0xFFF.
- R6: Status word A (0x30) has bit 2k+1 for a high violation and bit 2k for a low violation on voltage channel k (k = 0..7).
- R7: In status word B (0x31), bit 0 is instantaneous temperature low, bit 1 is instantaneous temperature high, bit 2 is averaged temperature low and bit 3 is averaged temperature high. Bits 15:4 read zero.
- R8: Status bits are sticky. They accumulate across channels and stay set after an alert side has released.
- R9: Writing a word with bit 2 set to 0x3F clears both status words. A write to 0x3F with bit 2 clear changes nothing.
- R10: If a violation is accepted in the same cycle as a clear command, the status bit for that violation is set after the clear.
- R11: Writes to 0x30 and 0x31 are ignored, because both status words are read-only.
- R12: A result whose channel tag is 10 or more is ignored. It does not change `alert` or the status words.
- R13: `alert` is the OR of the raised high and low sides of all ten channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A conversion result is presented this cycle |
| res_chan | input | 4 | Channel tag of the result (0..9 valid) |
| res_data | input | 12 | Unsigned conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| alert | output | 1 | High while any channel has a raised side |

## Verification
The directed cases drive results that sit exactly on a limit, one code past a limit, and exactly on or one code past the hysteresis release threshold. This separates strict from non-strict comparisons and shows whether N is added to or subtracted from the right side. A channel whose hysteresis is larger than its upper limit shows whether the threshold saturates or wraps around. Separate directed cases cover:
- a clear that coincides with a violation;
- a write aimed at a status word;
- a clear command with bit 2 low;
- an out-of-range channel tag.

The random phase then feeds values clustered around random limits on random channels, with sporadic clears, and compares `alert` and both status words against a reference model. This shows up mapping slips between channels and status bits, and any loss of the sticky behaviour.

// File: rtl/limit_alert_mon.sv
module limit_alert_mon #(
  parameter int DW   = 12,
  parameter int NVCH = 8,
  parameter int RW   = 16,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [3:0]    res_chan,
  input  logic [DW-1:0] res_data,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          alert
);
  localparam int NCH = NVCH + 2;
  localparam int NST = 2 * NCH;
  localparam int IW  = AW - 2;
  localparam int CLR_BIT = 2;
  localparam logic [DW-1:0] FS = '1;
  localparam logic [AW-1:0] A_STA = AW'(6'h30);
  localparam logic [AW-1:0] A_STB = AW'(6'h31);
  localparam logic [AW-1:0] A_CMD = AW'(6'h3F);

  logic [DW-1:0] up_q [NCH];
  logic [DW-1:0] lo_q [NCH];
  logic [DW-1:0] hy_q [NCH];
  logic [NCH-1:0] hi_act, lo_act;
  logic [NST-1:0] st_q, st_set;

  logic          in_rng, acc, clr, idx_ok;
  logic [3:0]    ci;
  logic [1:0]    bank;
  logic [IW-1:0] idx;
  logic [DW-1:0] up_sel, lo_sel, hy_sel, hi_thr, lo_thr;
  logic [DW:0]   lo_sum;
  logic          viol_hi, viol_lo, rel_hi, rel_lo;

  assign in_rng = res_chan < 4'(NCH);
  assign acc    = res_valid && in_rng;
  assign ci     = in_rng ? res_chan : '0;
  assign up_sel = up_q[ci];
  assign lo_sel = lo_q[ci];
  assign hy_sel = hy_q[ci];

  assign hi_thr = (up_sel >= hy_sel) ? up_sel - hy_sel : '0;
  assign lo_sum = {1'b0, lo_sel} + {1'b0, hy_sel};
  assign lo_thr = lo_sum[DW] ? FS : lo_sum[DW-1:0];

  assign viol_hi = acc && (res_data > up_sel);
  assign viol_lo = acc && (res_data < lo_sel);
  assign rel_hi  = acc && (res_data < hi_thr);
  assign rel_lo  = acc && (res_data > lo_thr);
  assign st_set  = NST'({viol_hi, viol_lo}) << {ci, 1'b0};

  assign bank   = reg_addr[AW-1:AW-2];
  assign idx    = reg_addr[IW-1:0];
  assign idx_ok = idx < IW'(NCH);
  assign clr    = reg_wr && (reg_addr == A_CMD) && reg_wdata[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        up_q[i] <= FS;
        lo_q[i] <= '0;
        hy_q[i] <= '0;
      end
    end else if (reg_wr && idx_ok) begin
      case (bank)
        2'd0:    up_q[idx] <= reg_wdata[DW-1:0];
        2'd1:    lo_q[idx] <= reg_wdata[DW-1:0];
        2'd2:    hy_q[idx] <= reg_wdata[DW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_act <= '0;
      lo_act <= '0;
      st_q   <= '0;
    end else begin
      if (viol_hi)     hi_act[ci] <= 1'b1;
      else if (rel_hi) hi_act[ci] <= 1'b0;
      if (viol_lo)     lo_act[ci] <= 1'b1;
      else if (rel_lo) lo_act[ci] <= 1'b0;
      st_q <= (clr ? '0 : st_q) | st_set;
    end
  end

  assign alert = |{hi_act, lo_act};

  always_comb begin
    reg_rdata = '0;
    case (bank)
      2'd0: if (idx_ok) reg_rdata = RW'(up_q[idx]);
      2'd1: if (idx_ok) reg_rdata = RW'(lo_q[idx]);
      2'd2: if (idx_ok) reg_rdata = RW'(hy_q[idx]);
      default: begin
        if (reg_addr == A_STA)      reg_rdata = RW'(st_q[2*NVCH-1:0]);
        else if (reg_addr == A_STB) reg_rdata = RW'(st_q[NST-1:2*NVCH]);
      end
    endcase
  end
endmodule

// File: rtl/limit_alert_mon_chk.sv
module limit_alert_mon_chk #(
  parameter int DW = 12,
  parameter int RW = 16,
  parameter int AW = 6,
  parameter int NST = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          res_valid,
  input logic [3:0]    res_chan,
  input logic [DW-1:0] res_data,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [RW-1:0] reg_wdata,
  input logic [RW-1:0] reg_rdata,
  input logic          alert,
  input logic [DW-1:0] up_sel,
  input logic [NST-1:0] st
);
  logic clr_cmd;
  assign clr_cmd = reg_wr && reg_addr == AW'(6'h3F) && reg_wdata[2];

  p_hyst_top_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[AW-1:AW-2] == 2'd2) |-> (reg_rdata[RW-1:DW] == '0));

  p_high_alert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_chan < 4'd10 && res_data > up_sel) |=> alert);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> ((st & $past(st)) == $past(st)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !res_valid) |=> (st == '0));

  p_statb_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(6'h31)) |-> (reg_rdata[RW-1:4] == '0));
endmodule

bind limit_alert_mon limit_alert_mon_chk #(.DW(DW), .RW(RW), .AW(AW), .NST(NST)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
  .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert(alert),
  .up_sel(up_sel), .st(st_q)
);

// File: tb/sim_limit_alert_mon.sv
module sim_limit_alert_mon;
  logic clk = 0, rst_n = 0;
  logic res_valid = 0, reg_wr = 0;
  logic [3:0] res_chan = 0;
  logic [11:0] res_data = 0;
  logic [5:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic alert;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mup[10], mlo[10], mhy[10];
  bit mhi[10], mlw[10];
  bit [19:0] mst;

  always #2 clk = ~clk;

  limit_alert_mon u0 (.clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alert(alert));

  function automatic int hthr(int up, int n);
    return (up >= n) ? up - n : 0;
  endfunction
  function automatic int lthr(int lo, int n);
    return (lo + n > 4095) ? 4095 : lo + n;
  endfunction
  function automatic bit exp_alert();
    bit a = 0;
    for (int i = 0; i < 10; i++) a |= mhi[i] | mlw[i];
    return a;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, int exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic set_lim(int c, int up, int lo, int n);
    wr(6'(c), 16'(up)); wr(6'(16 + c), 16'(lo)); wr(6'(32 + c), 16'(n));
    mup[c] = up; mlo[c] = lo; mhy[c] = n;
  endtask

  task automatic send(int c, int d, bit clr);
    @(negedge clk);
    res_valid = 1; res_chan = 4'(c); res_data = 12'(d);
    if (clr) begin reg_wr = 1; reg_addr = 6'h3F; reg_wdata = 16'h0004; end
    @(negedge clk);
    res_valid = 0; reg_wr = 0;
    if (clr) mst = '0;
    if (c < 10) begin
      if (d > mup[c]) begin mhi[c] = 1; mst[2*c+1] = 1; end
      else if (d < hthr(mup[c], mhy[c])) mhi[c] = 0;
      if (d < mlo[c]) begin mlw[c] = 1; mst[2*c] = 1; end
      else if (d > lthr(mlo[c], mhy[c])) mlw[c] = 0;
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 10; i++) begin
      mup[i] = 4095; mlo[i] = 0; mhy[i] = 0; mhi[i] = 0; mlw[i] = 0;
    end
    mst = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R1 R2 reset state
    rd(6'h20, 0, "R1 hyst reset");
    rd(6'h29, 0, "R1 hyst reset ch9");
    rd(6'h00, 12'hFFF, "R2 upper reset");
    rd(6'h19, 0, "R2 lower reset");
    check("R2 alert after reset", alert, 0);
    send(3, 4095, 0);
    send(5, 0, 0);
    check("R2 no alert at full range", alert, 0);
    rd(6'h30, 0, "R2 status A after reset");
    wr(6'h20, 16'hFFFF);
    rd(6'h20, 16'h0FFF, "R1 hyst top bits zero");

    // R3 R4 R6 high side with N=8
    set_lim(0, 100, 0, 8);
    send(0, 100, 0);
    check("R3 equal to upper no alert", alert, 0);
    send(0, 101, 0);
    check("R3 alert above upper", alert, 1);
    rd(6'h30, 16'h0002, "R6 ch0 high bit1");
    send(0, 92, 0);
    check("R4 hold at upper-N", alert, 1);
    send(0, 91, 0);
    check("R4 release below upper-N", alert, 0);
    rd(6'h30, 16'h0002, "R8 sticky after release");

    // R5 low side on ch3
    set_lim(3, 4095, 50, 10);
    send(3, 49, 0);
    check("R5 alert below lower", alert, 1);
    rd(6'h30, 16'h0042, "R6 R8 ch3 low bit6 accumulates");
    send(3, 60, 0);
    check("R5 hold at lower+N", alert, 1);
    send(3, 61, 0);
    check("R5 release above lower+N", alert, 0);

    // R7 temperature channels
    set_lim(8, 200, 0, 0);
    send(8, 201, 0);
    rd(6'h31, 16'h0002, "R7 instantaneous high bit1");
    set_lim(9, 4095, 10, 0);
    send(9, 5, 0);
    rd(6'h31, 16'h0006, "R7 averaged low bit2");
    check("R13 alert OR of two channels", alert, 1);
    send(8, 0, 0);
    check("R13 alert held by other channel", alert, 1);
    send(9, 100, 0);
    check("R13 alert low after all release", alert, 0);

    // R11 R9
    wr(6'h30, 16'hFFFF);
    wr(6'h31, 16'h0000);
    rd(6'h30, 16'h0042, "R11 status A read-only");
    rd(6'h31, 16'h0006, "R11 status B read-only");
    wr(6'h3F, 16'hFFFB);
    rd(6'h30, 16'h0042, "R9 cmd without bit2 no effect");
    wr(6'h3F, 16'h0004);
    rd(6'h30, 0, "R9 clear status A");
    rd(6'h31, 0, "R9 clear status B");

    // R10 clear with simultaneous violation
    set_lim(7, 10, 0, 0);
    send(0, 200, 0);
    send(7, 20, 1);
    rd(6'h30, 16'h8000, "R10 new violation survives clear");
    send(7, 0, 0);
    send(0, 0, 0);
    check("R10 released", alert, 0);

    // R12 out-of-range tag
    send(12, 4095, 0);
    check("R12 ignored tag alert", alert, 0);
    rd(6'h30, 16'h8000, "R12 ignored tag status A");
    rd(6'h31, 0, "R12 ignored tag status B");

    // R4 saturation: N > upper never releases
    set_lim(1, 5, 0, 10);
    send(1, 6, 0);
    send(1, 0, 0);
    check("R4 saturated threshold holds", alert, 1);

    // random phase
    do_reset();
    for (int c = 0; c < 10; c++)
      set_lim(c, $urandom_range(2000, 4095), $urandom_range(0, 2000), $urandom_range(0, 300));
    for (int it = 0; it < 600; it++) begin
      int c, base, d;
      c = $urandom_range(0, 11);
      base = (c < 10) ? (($urandom_range(0, 1) == 1) ? mup[c] : mlo[c]) : 2000;
      d = base + $urandom_range(0, 700) - 350;
      if (d < 0) d = 0;
      if (d > 4095) d = 4095;
      send(c, d, $urandom_range(0, 29) == 0);
      check("R13 random alert", alert, exp_alert());
      if (it % 16 == 15) begin
        rd(6'h30, int'(mst[15:0]), "R6 R8 random status A");
        rd(6'h31, int'(mst[19:16]), "R7 R8 random status B");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule